// File: doc/BRIEF.md
# Shared-Pin Serial Register Read Slave

This block is the peripheral end of a serial register read link. A host opens a frame by raising the enable line. It then clocks 32 serial clocks. The first data-in bit selects a read. The next six bits form a register address, sent most significant bit first. The block answers with the 24-bit contents of that register, also most significant bit first. The block runs directly on the serial clock.

The single serial output pin is shared with a lock-status signal. While no read data is being returned, the pin follows the lock-detect input combinationally. The pin switches to register data only for the 24 data clocks. It returns to lock status on the final clock of the frame. It also returns at once whenever enable falls. The register bank is a flat input vector, so that any register file can feed the block.

Top module: `serial_read_slave`

## Requirements
- R1: The data-in level sampled on the first rising clock edge with enable high selects the frame type: 1 is a read, 0 means every further bit of that frame is ignored and the pin keeps showing lock detect until enable drops.
- R2: In a read frame, data-in sampled on rising edges 2 to 7 forms the register address, first bit is address bit 5 (MSB); register k occupies bank bits [24k+23 : 24k].
- R3: In a read frame, after rising edge n (n = 8 to 31) the output pin shows bit 31-n of the addressed register, so bit 23 appears after edge 8 and bit 0 after edge 31.
- R4: Whenever the block is not in the read data phase, the output pin equals the lock-detect input and follows its changes without waiting for a clock edge.
- R5: After rising edge 32 the pin carries lock detect again, and further edges while enable stays high leave it on lock detect.
- R6: Enable low clears the bit counter and frame state, so a frame cut short is discarded and the next frame decodes from edge 1.
- R7: The active-high synchronous reset clears the frame state on a rising edge, and the pin then shows lock detect.
- R8: While enable is low the pin shows lock detect immediately, even when enable drops during the data phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sen | input | 1 | Frame enable, high for the duration of a frame |
| sdi | input | 1 | Serial data in (read flag, then address) |
| lock_in | input | 1 | Live lock-detect status to show on the shared pin |
| bank_flat | input | NREG*DW | Register bank, register k at bits [DW*k +: DW] |
| sdo | output | 1 | Shared pin: lock detect or read data |

## Verification
A miscounted frame counter appears on the pin within one clock. The first data bit arrives on the wrong edge, or lock detect comes back early or late. The next negative-edge comparison catches either case. A wrong captured address bit stays hidden until edge 8, then gives a wrong word of data. A shift fault corrupts the bit on the edge where it occurs. The lock-detect input is randomised on every clock. A mux select stuck in the data phase therefore shows up as a mismatch within a few clocks of any frame's end.

// File: rtl/srd_pkg.sv
package srd_pkg;

    localparam int unsigned ADDR_W_DEF = 6;
    localparam int unsigned DATA_W_DEF = 24;

    typedef enum logic [1:0] {
        FR_WAIT = 2'd0,
        FR_READ = 2'd1,
        FR_SKIP = 2'd2
    } frame_mode_e;

    typedef struct packed {
        logic addr_en;
        logic load_en;
        logic data_start;
        logic shift_en;
        logic data_end;
    } frame_strobe_t;

    // Total serial clocks in one frame: flag, address, data, restore.
    function automatic int unsigned frame_len(int unsigned aw, int unsigned dw);
        return 1 + aw + dw + 1;
    endfunction

endpackage

// File: rtl/srd_frame_ctl.sv
module srd_frame_ctl
    import srd_pkg::*;
#(
    parameter int unsigned AW = ADDR_W_DEF,
    parameter int unsigned DW = DATA_W_DEF
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          sdi,
    output frame_strobe_t stb
);
    localparam int unsigned FRAME = frame_len(AW, DW);
    localparam int unsigned CW    = $clog2(FRAME + 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(FRAME);
    localparam logic [CW:0]   E_ADDR   = (CW+1)'(2);
    localparam logic [CW:0]   E_LOAD   = (CW+1)'(AW + 1);
    localparam logic [CW:0]   E_START  = (CW+1)'(AW + 2);
    localparam logic [CW:0]   E_SHLAST = (CW+1)'(AW + DW + 1);
    localparam logic [CW:0]   E_END    = (CW+1)'(FRAME);

    logic [CW-1:0] cnt;
    frame_mode_e   mode;
    logic [CW:0]   edge_no;
    logic          active;
    logic          rd;

    assign edge_no = {1'b0, cnt} + 1'b1;
    assign active  = (cnt != CNT_MAX);
    assign rd      = active && (mode == FR_READ);

    always_comb begin
        stb            = '0;
        stb.addr_en    = rd && (edge_no >= E_ADDR) && (edge_no <= E_LOAD);
        stb.load_en    = rd && (edge_no == E_LOAD);
        stb.data_start = rd && (edge_no == E_START);
        stb.shift_en   = rd && (edge_no > E_START) && (edge_no <= E_SHLAST);
        stb.data_end   = active && (edge_no == E_END);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt  <= '0;
            mode <= FR_WAIT;
        end else begin
            if (active) begin
                cnt <= cnt + 1'b1;
            end
            if (mode == FR_WAIT) begin
                mode <= sdi ? FR_READ : FR_SKIP;
            end
        end
    end

endmodule

// File: rtl/srd_addr_select.sv
module srd_addr_select
    import srd_pkg::*;
#(
    parameter int unsigned AW   = ADDR_W_DEF,
    parameter int unsigned DW   = DATA_W_DEF,
    parameter int unsigned NREG = 64
) (
    input  logic               clk,
    input  logic               clr,
    input  logic               addr_en,
    input  logic               sdi,
    input  logic [NREG*DW-1:0] bank_flat,
    output logic [DW-1:0]      sel_word
);
    localparam int unsigned SPAN = 1 << AW;

    logic [AW-2:0] addr_sh;
    logic [AW-1:0] full_addr;

    // The last address bit is taken straight from the line at the load edge.
    assign full_addr = {addr_sh, sdi};

    always_ff @(posedge clk) begin
        if (clr) begin
            addr_sh <= '0;
        end else if (addr_en) begin
            addr_sh <= (AW-1)'({addr_sh, sdi});
        end
    end

    generate
        if (NREG >= SPAN) begin : g_full_bank
            assign sel_word = bank_flat[int'(full_addr)*DW +: DW];
        end else begin : g_part_bank
            assign sel_word = (int'(full_addr) < NREG) ?
                              bank_flat[int'(full_addr)*DW +: DW] : '0;
        end
    endgenerate

endmodule

// File: rtl/srd_data_shift.sv
module srd_data_shift
    import srd_pkg::*;
#(
    parameter int unsigned DW = DATA_W_DEF
) (
    input  logic          clk,
    input  logic          clr,
    input  frame_strobe_t stb,
    input  logic [DW-1:0] load_word,
    input  logic          sen,
    input  logic          lock_in,
    output logic          sdo
);
    logic [DW-1:0] shreg;
    logic          data_phase;

    always_ff @(posedge clk) begin
        if (clr) begin
            shreg      <= '0;
            data_phase <= 1'b0;
        end else begin
            if (stb.load_en) begin
                shreg <= load_word;
            end else if (stb.shift_en) begin
                shreg <= {shreg[DW-2:0], 1'b0};
            end
            if (stb.data_start) begin
                data_phase <= 1'b1;
            end else if (stb.data_end) begin
                data_phase <= 1'b0;
            end
        end
    end

    assign sdo = (sen && data_phase) ? shreg[DW-1] : lock_in;

endmodule

// File: rtl/serial_read_slave.sv
module serial_read_slave
    import srd_pkg::*;
#(
    parameter int unsigned AW   = ADDR_W_DEF,
    parameter int unsigned DW   = DATA_W_DEF,
    parameter int unsigned NREG = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sen,
    input  logic               sdi,
    input  logic               lock_in,
    input  logic [NREG*DW-1:0] bank_flat,
    output logic               sdo
);
    logic          clr;
    frame_strobe_t stb;
    logic [DW-1:0] sel_word;

    assign clr = rst | ~sen;

    srd_frame_ctl #(.AW(AW), .DW(DW)) u_ctl (
        .clk (clk),
        .clr (clr),
        .sdi (sdi),
        .stb (stb)
    );

    srd_addr_select #(.AW(AW), .DW(DW), .NREG(NREG)) u_addr (
        .clk       (clk),
        .clr       (clr),
        .addr_en   (stb.addr_en),
        .sdi       (sdi),
        .bank_flat (bank_flat),
        .sel_word  (sel_word)
    );

    srd_data_shift #(.DW(DW)) u_shift (
        .clk       (clk),
        .clr       (clr),
        .stb       (stb),
        .load_word (sel_word),
        .sen       (sen),
        .lock_in   (lock_in),
        .sdo       (sdo)
    );

endmodule

// File: rtl/srd_checker.sv
module srd_checker #(
    parameter int unsigned AW = 6,
    parameter int unsigned DW = 24
) (
    input logic clk,
    input logic rst,
    input logic sen,
    input logic sdi,
    input logic lock_in,
    input logic sdo
);
    localparam int FIRST_DATA = AW + 2;
    localparam int LAST_DATA  = AW + DW + 1;
    localparam int FRAME      = AW + DW + 2;

    logic [7:0] ch_cnt;
    logic       ch_rd;

    always_ff @(posedge clk) begin
        if (rst || !sen) begin
            ch_cnt <= '0;
            ch_rd  <= 1'b0;
        end else begin
            if (ch_cnt != 8'hFF) ch_cnt <= ch_cnt + 1'b1;
            if (ch_cnt == 8'd0)  ch_rd  <= sdi;
        end
    end

    AST_IDLE_LOCK: assert property (@(posedge clk) disable iff (rst)
        !sen |-> (sdo == lock_in)); // R8

    AST_OUTSIDE_DATA_LOCK: assert property (@(posedge clk) disable iff (rst)
        (sen && !(ch_rd && int'(ch_cnt) >= FIRST_DATA && int'(ch_cnt) <= LAST_DATA))
        |-> (sdo == lock_in)); // R4

    AST_SKIP_FRAME_LOCK: assert property (@(posedge clk) disable iff (rst)
        (sen && ch_cnt != 8'd0 && !ch_rd) |-> (sdo == lock_in)); // R1

    AST_RESTORE_LOCK: assert property (@(posedge clk) disable iff (rst)
        (sen && int'(ch_cnt) >= FRAME) |-> (sdo == lock_in)); // R5

    AST_RESET_LOCK: assert property (@(posedge clk)
        $past(rst) |-> (sdo == lock_in)); // R7

endmodule

bind serial_read_slave srd_checker #(.AW(AW), .DW(DW)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .sen     (sen),
    .sdi     (sdi),
    .lock_in (lock_in),
    .sdo     (sdo)
);

// File: tb/serial_read_slave_tb_top.sv
`timescale 1ns/1ps
module serial_read_slave_tb_top;

    localparam int AW   = 6;
    localparam int DW   = 24;
    localparam int NREG = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sen = 1'b0;
    logic sdi = 1'b0;
    logic lock_in = 1'b0;
    logic [NREG*DW-1:0] bank_flat;
    logic sdo;

    logic [DW-1:0] bank_mem [NREG];

    int checks = 0;
    int fails  = 0;
    bit started = 0;
    bit done = 0;
    string scen = "R4";

    // Behavioural reference state
    int m_cnt  = 0;
    int m_rd   = 0;
    int m_addr = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int k = 0; k < NREG; k++) bank_flat[k*DW +: DW] = bank_mem[k];
    end

    serial_read_slave #(.AW(AW), .DW(DW), .NREG(NREG)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .sen       (sen),
        .sdi       (sdi),
        .lock_in   (lock_in),
        .bank_flat (bank_flat),
        .sdo       (sdo)
    );

    always @(posedge clk) begin
        started = 1;
        if (rst || !sen) begin
            m_cnt = 0; m_rd = 0; m_addr = 0;
        end else begin
            m_cnt = m_cnt + 1;
            if (m_cnt == 1) m_rd = int'(sdi);
            else if (m_cnt <= AW + 1) m_addr = ((m_addr << 1) | int'(sdi)) & ((1 << AW) - 1);
        end
    end

    function automatic string phase_tag();
        if (rst) return "R7";
        if (!sen) return "R8";
        if (m_cnt == 0) return "R4";
        if (m_rd == 0) return "R1";
        if (m_cnt >= AW + 2 && m_cnt <= AW + DW + 1) return "R2 R3";
        if (m_cnt >= AW + DW + 2) return "R5";
        return "R4";
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t cnt=%0d actual=%b expected=%b", tag, $time, m_cnt, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the reference model
    always @(negedge clk) begin
        if (started && !done) begin
            logic exp;
            if (sen && m_rd == 1 && m_cnt >= AW + 2 && m_cnt <= AW + DW + 1)
                exp = bank_mem[m_addr][DW - 1 - (m_cnt - (AW + 2))];
            else
                exp = lock_in;
            check({phase_tag(), " ", scen}, sdo, exp);
        end
    end

    task automatic drive_frame(input bit rd, input int addr, input int n_edges);
        for (int i = 1; i <= n_edges; i++) begin
            @(negedge clk); #2;
            sen = 1'b1;
            if (i == 1) sdi = rd;
            else if (i <= AW + 1) sdi = addr[AW - i + 1];
            else sdi = 1'($urandom);
            lock_in = 1'($urandom);
        end
        @(negedge clk); #2;
        sen = 1'b0;
        sdi = 1'($urandom);
        #1 check("R8", sdo, lock_in);
        lock_in = ~lock_in;
        #1 check("R8", sdo, lock_in);
        repeat (2) begin
            @(negedge clk); #2;
            lock_in = 1'($urandom);
        end
    endtask

    initial begin
        #500us;
        fails++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < NREG; k++) bank_mem[k] = DW'($urandom);
        bank_mem[0]  = 24'hA50F3C;
        bank_mem[63] = 24'hFFFFFF;
        bank_mem[42] = 24'h555555;
        bank_mem[21] = 24'h800001;

        // R7: reset state shows lock detect
        scen = "R7";
        repeat (3) @(posedge clk);
        @(negedge clk); #2; lock_in = 1'b1;
        #1 check("R7", sdo, 1'b1);
        lock_in = 1'b0;
        #1 check("R7", sdo, 1'b0);
        @(negedge clk); #2; rst = 1'b0;

        scen = "R2 R3";
        drive_frame(1, 0, 32);
        drive_frame(1, 63, 32);
        drive_frame(1, 42, 32);
        drive_frame(1, 21, 32);
        for (int j = 0; j < 6; j++) drive_frame(1, int'($urandom_range(0, 63)), 32);

        // R1: non-read frames keep lock detect
        scen = "R1";
        drive_frame(0, 63, 32);
        drive_frame(0, 0, 32);

        // R6: truncated frames discarded, next frame decodes afresh
        scen = "R6";
        drive_frame(1, 42, 4);
        drive_frame(1, 63, 32);
        drive_frame(1, 0, 15);
        drive_frame(1, 21, 32);
        drive_frame(0, 0, 3);
        drive_frame(1, 42, 32);

        // R5: extra edges after the frame keep lock detect
        scen = "R5";
        drive_frame(1, 63, 40);

        // R7: reset during the data phase
        scen = "R7";
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk); #2;
            sen = 1'b1;
            sdi = (i == 1) ? 1'b1 : (i <= AW + 1) ? 1'b1 : 1'b0;
            lock_in = 1'b0;
        end
        @(negedge clk); #2; rst = 1'b1;
        @(negedge clk); #1;
        check("R7", sdo, lock_in);
        #1; sen = 1'b0;
        @(negedge clk); #2; rst = 1'b0;
        scen = "R6";
        drive_frame(1, 21, 32);

        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule